// File: doc/BRIEF.md
# ATA Task-File Register Controller

This block holds the host-visible register file of one ATA channel that serves two drive slots. A host bus master performs byte-wide reads and writes at a small offset space. Offsets 1 to 7 hold the command-block registers. Offset 8 is the device-control register, and offset 9 is the alternate address register. Offset 0 is the data port, which this block does not handle. Two input pins per slot report whether a device is fitted and whether it is a packet (optical) device or a disk.

The block tracks soft-reset sequencing on the edges of the reset bit in the device-control register. It decodes the identify, packet and set-features commands against the type of the selected slot and aborts any command that does not match that type. It raises a one-cycle interrupt pulse, which the interrupt-disable bit can mask. The data payload and the media are handled elsewhere. When a command needs data, this block emits a one-cycle transfer-start strobe together with the length and direction of the transfer.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: After reset, reads return status 0x00, error 0x01 and drive/head 0x00. Sector count and sector number read 1 and both cylinder bytes read 0 in each slot. The device-control register holds 0x08. `irq` and `xfer_start` are 0.
- R2: A write to offset 6 stores the value with bits 7 and 5 forced to 1. Bit 4 of the stored value selects the slot that offsets 2 to 5 address, and bit 6 is the LBA flag.
- R3: Selecting a slot whose `slot_present` bit is 0 sets error bit 2 and status bit 0. While such a slot is selected, offset 6 reads 0xA0 and offsets 1 to 5, 7 and 8 read 0.
- R4: Sector count (offset 2), sector number (3), cylinder low (4) and cylinder high (5) are held separately for each slot. A read at offset 1 returns the error register and never the features byte. Offset 8 reads the status register. Offset 9 always reads 0xFF. Offsets 0 and 10 to 15 read 0.
- R5: A device-control write that takes bit 2 from 0 to 1 sets status to 0x90 and error to 0x01, and clears the command register. The control register then stores the written value with bit 1 cleared.
- R6: A device-control write that takes bit 2 from 1 to 0 clears status bit 7, sets status bit 6 and clears drive/head bits 3:0. In every slot it sets sector count and sector number to 1. The cylinder becomes 0xEB14 (low byte 0x14, high byte 0xEB) in a packet slot and 0x0000 in any other slot.
- R7: An aborted command sets status to 0x41 and error to 0x04 and raises the interrupt.
- R8: Command 0xEC on a disk slot, or 0xA1 on a packet slot, sets error to 0x00 and status to 0x58 and raises the interrupt. It also pulses `xfer_start` with `xfer_len` = 512 and `xfer_to_device` = 0. Command 0xEC on any slot that is not a disk aborts, and so does 0xA1 on any slot that is not a packet slot.
- R9: Command 0xA0 on a packet slot sets that slot's sector count to 1 and clears status bits 7, 5 and 0. It sets status bit 3 and pulses `xfer_start` with `xfer_len` = 12 and `xfer_to_device` = 1, with no interrupt. Command 0xA0 on any other slot aborts.
- R10: Command 0xEF clears status bits 7, 5 and 0, sets status bits 6 and 4, and raises the interrupt.
- R11: A command code other than 0xEC, 0xA1, 0xA0 and 0xEF leaves status and error unchanged and produces no interrupt and no transfer strobe.
- R12: `irq` is high for exactly the one cycle after the command write that raised it. It is raised only if bit 1 of the device-control register is 0 at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 4 | Register offset |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| slot_present | input | 2 | Device fitted, one bit per slot |
| slot_is_packet | input | 2 | Fitted device is a packet device, one bit per slot |
| irq | output | 1 | Interrupt pulse |
| xfer_start | output | 1 | Data transfer start strobe |
| xfer_len | output | 12 | Byte length of the transfer just started |
| xfer_to_device | output | 1 | 1 = host writes the data, 0 = host reads it |
| active_slot | output | 1 | Slot currently selected by drive/head bit 4 |
| cmd_code | output | 8 | Last command code written |
| features | output | 8 | Features byte last written at offset 1 |

## Verification
The hardest state to reach is the error left behind by selecting an empty slot. While that slot stays selected, every read is masked to 0 or 0xA0, so the abort bit is visible only after the host reselects a fitted slot. The stimulus therefore changes the presence pins between phases and mixes random drive/head writes with directed select-away sequences. Soft-reset falls are also driven while the slot types differ, so the two reset cylinder values both reach the ports.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam logic [3:0] OFF_DATA    = 4'd0;
  localparam logic [3:0] OFF_ERRFEAT = 4'd1;
  localparam logic [3:0] OFF_SCNT    = 4'd2;
  localparam logic [3:0] OFF_SNUM    = 4'd3;
  localparam logic [3:0] OFF_CYLLO   = 4'd4;
  localparam logic [3:0] OFF_CYLHI   = 4'd5;
  localparam logic [3:0] OFF_DRVHD   = 4'd6;
  localparam logic [3:0] OFF_CMDSTAT = 4'd7;
  localparam logic [3:0] OFF_DEVCTL  = 4'd8;
  localparam logic [3:0] OFF_ALTADR  = 4'd9;

  localparam int ST_BSY = 7;
  localparam int ST_RDY = 6;
  localparam int ST_WFT = 5;
  localparam int ST_DSC = 4;
  localparam int ST_DRQ = 3;
  localparam int ST_ERR = 0;

  localparam int CTL_SRST = 2;
  localparam int CTL_NIEN = 1;
  localparam int DH_SLOT  = 4;
  localparam int ER_ABRT  = 2;

  localparam logic [7:0] CMD_IDENT_DISK = 8'hEC;
  localparam logic [7:0] CMD_IDENT_PKT  = 8'hA1;
  localparam logic [7:0] CMD_PACKET     = 8'hA0;
  localparam logic [7:0] CMD_SETFEAT    = 8'hEF;

  typedef enum logic [1:0] {KIND_NONE, KIND_DISK, KIND_PACKET} dev_kind_t;
  typedef enum logic [2:0] {ACT_NONE, ACT_ABORT, ACT_IDENT, ACT_PKT, ACT_SETF} cmd_act_t;
endpackage

// File: rtl/ata_tf_cmd_decode.sv
module ata_tf_cmd_decode
  import ata_tf_pkg::*;
(
  input  logic [7:0] cmd_byte,
  input  dev_kind_t  kind,
  output cmd_act_t   act
);
  always_comb begin
    act = ACT_NONE;
    unique case (cmd_byte)
      CMD_IDENT_DISK: act = (kind == KIND_DISK)   ? ACT_IDENT : ACT_ABORT;
      CMD_IDENT_PKT:  act = (kind == KIND_PACKET) ? ACT_IDENT : ACT_ABORT;
      CMD_PACKET:     act = (kind == KIND_PACKET) ? ACT_PKT   : ACT_ABORT;
      CMD_SETFEAT:    act = ACT_SETF;
      default:        act = ACT_NONE;
    endcase
  end

  // R9: a packet transfer is only granted to a packet slot
  always_comb begin
    p_pkt_kind_r9: assert (act != ACT_PKT || kind == KIND_PACKET);
  end
endmodule

// File: rtl/ata_tf_slot_regs.sv
module ata_tf_slot_regs #(
  parameter logic [15:0] PKT_CYL  = 16'hEB14,
  parameter logic [15:0] DISK_CYL = 16'h0000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fld_we,
  input  logic [1:0] fld_sel,
  input  logic [7:0] fld_wdata,
  input  logic       cnt_to_one,
  input  logic       rst_done,
  input  logic       is_packet,
  output logic [7:0] scnt,
  output logic [7:0] snum,
  output logic [7:0] cyl_lo,
  output logic [7:0] cyl_hi
);
  localparam int NFLD = 4;

  logic [7:0] fld_q [NFLD];
  logic [7:0] fld_d [NFLD];
  logic [15:0] cyl_init;

  assign cyl_init = is_packet ? PKT_CYL : DISK_CYL;

  always_comb begin
    for (int i = 0; i < NFLD; i++) fld_d[i] = fld_q[i];
    if (rst_done) begin
      fld_d[0] = 8'd1;
      fld_d[1] = 8'd1;
      fld_d[2] = cyl_init[7:0];
      fld_d[3] = cyl_init[15:8];
    end else if (cnt_to_one) begin
      fld_d[0] = 8'd1;
    end else if (fld_we) begin
      fld_d[fld_sel] = fld_wdata;
    end
  end

  generate
    for (genvar g = 0; g < NFLD; g++) begin : g_fld
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      fld_q[g] <= (g < 2) ? 8'd1 : 8'd0;
        else if (rst_done || cnt_to_one || fld_we) fld_q[g] <= fld_d[g];
      end
    end
  endgenerate

  assign scnt   = fld_q[0];
  assign snum   = fld_q[1];
  assign cyl_lo = fld_q[2];
  assign cyl_hi = fld_q[3];

  p_slot_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_done |=> (scnt == 8'd1 && snum == 8'd1 &&
                  {cyl_hi, cyl_lo} == ($past(is_packet) ? PKT_CYL : DISK_CYL)));
endmodule

// File: rtl/ata_tf_read_mux.sv
module ata_tf_read_mux
  import ata_tf_pkg::*;
(
  input  logic [3:0] addr,
  input  logic       slot_empty,
  input  logic [7:0] err,
  input  logic [7:0] dh,
  input  logic [7:0] stat,
  input  logic [7:0] sc,
  input  logic [7:0] sn,
  input  logic [7:0] cl,
  input  logic [7:0] ch,
  output logic [7:0] rd_data
);
  logic [7:0] raw;

  always_comb begin
    unique case (addr)
      OFF_ERRFEAT: raw = err;
      OFF_SCNT:    raw = sc;
      OFF_SNUM:    raw = sn;
      OFF_CYLLO:   raw = cl;
      OFF_CYLHI:   raw = ch;
      OFF_DRVHD:   raw = dh;
      OFF_CMDSTAT: raw = stat;
      OFF_DEVCTL:  raw = stat;
      default:     raw = 8'h00;
    endcase
  end

  always_comb begin
    if (addr == OFF_ALTADR)                      rd_data = 8'hFF;
    else if (slot_empty && addr == OFF_DRVHD)    rd_data = 8'hA0;
    else if (slot_empty)                         rd_data = 8'h00;
    else                                         rd_data = raw;
  end
endmodule

// File: rtl/ata_taskfile_ctrl.sv
module ata_taskfile_ctrl
  import ata_tf_pkg::*;
#(
  parameter int LEN_W        = 12,
  parameter int IDENT_BYTES  = 512,
  parameter int PACKET_BYTES = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       addr,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic [1:0]       slot_present,
  input  logic [1:0]       slot_is_packet,
  output logic             irq,
  output logic             xfer_start,
  output logic [LEN_W-1:0] xfer_len,
  output logic             xfer_to_device,
  output logic             active_slot,
  output logic [7:0]       cmd_code,
  output logic [7:0]       features
);
  localparam int NSLOT = 2;
  localparam logic [LEN_W-1:0] ID_LEN  = LEN_W'(IDENT_BYTES);
  localparam logic [LEN_W-1:0] PKT_LEN = LEN_W'(PACKET_BYTES);

  logic [7:0] err_q, err_d, stat_q, stat_d, ctrl_q, ctrl_d;
  logic [7:0] feat_q, feat_d, dh_q, dh_d, cmd_q, cmd_d;
  logic       irq_q, irq_d, xs_q, xs_d, xdir_q, xdir_d;
  logic [LEN_W-1:0] xlen_q, xlen_d;
  logic       raise;

  dev_kind_t  slot_kind [NSLOT];
  logic [7:0] sc_s [NSLOT];
  logic [7:0] sn_s [NSLOT];
  logic [7:0] cl_s [NSLOT];
  logic [7:0] ch_s [NSLOT];

  logic     sel;
  logic     wr_cmd, wr_ctl, srst_rise, srst_fall, wr_fld;
  cmd_act_t act;

  assign sel       = dh_q[DH_SLOT];
  assign wr_cmd    = wr_en && (addr == OFF_CMDSTAT);
  assign wr_ctl    = wr_en && (addr == OFF_DEVCTL);
  assign wr_fld    = wr_en && (addr >= OFF_SCNT) && (addr <= OFF_CYLHI);
  assign srst_rise = wr_ctl && !ctrl_q[CTL_SRST] &&  wr_data[CTL_SRST];
  assign srst_fall = wr_ctl &&  ctrl_q[CTL_SRST] && !wr_data[CTL_SRST];

  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign slot_kind[s] = !slot_present[s]  ? KIND_NONE :
                            slot_is_packet[s] ? KIND_PACKET : KIND_DISK;

      ata_tf_slot_regs u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .fld_we     (wr_fld && (sel == 1'(s))),
        .fld_sel    (2'(addr - OFF_SCNT)),
        .fld_wdata  (wr_data),
        .cnt_to_one (wr_cmd && (act == ACT_PKT) && (sel == 1'(s))),
        .rst_done   (srst_fall),
        .is_packet  (slot_kind[s] == KIND_PACKET),
        .scnt       (sc_s[s]),
        .snum       (sn_s[s]),
        .cyl_lo     (cl_s[s]),
        .cyl_hi     (ch_s[s])
      );
    end
  endgenerate

  ata_tf_cmd_decode u_dec (
    .cmd_byte (wr_data),
    .kind     (slot_kind[sel]),
    .act      (act)
  );

  ata_tf_read_mux u_rd (
    .addr       (addr),
    .slot_empty (slot_kind[sel] == KIND_NONE),
    .err        (err_q),
    .dh         (dh_q),
    .stat       (stat_q),
    .sc         (sc_s[sel]),
    .sn         (sn_s[sel]),
    .cl         (cl_s[sel]),
    .ch         (ch_s[sel]),
    .rd_data    (rd_data)
  );

  always_comb begin
    err_d  = err_q;
    stat_d = stat_q;
    ctrl_d = ctrl_q;
    feat_d = feat_q;
    dh_d   = dh_q;
    cmd_d  = cmd_q;
    xs_d   = 1'b0;
    xlen_d = xlen_q;
    xdir_d = xdir_q;
    raise  = 1'b0;
    if (wr_en) begin
      unique case (addr)
        OFF_ERRFEAT: feat_d = wr_data;
        OFF_DRVHD: begin
          dh_d = wr_data | 8'hA0;
          if (slot_kind[wr_data[DH_SLOT]] == KIND_NONE) begin
            err_d[ER_ABRT] = 1'b1;
            stat_d[ST_ERR] = 1'b1;
          end
        end
        OFF_CMDSTAT: begin
          cmd_d = wr_data;
          unique case (act)
            ACT_ABORT: begin
              stat_d = 8'h41;
              err_d  = 8'h04;
              raise  = 1'b1;
            end
            ACT_IDENT: begin
              stat_d = 8'h58;
              err_d  = 8'h00;
              raise  = 1'b1;
              xs_d   = 1'b1;
              xlen_d = ID_LEN;
              xdir_d = 1'b0;
            end
            ACT_PKT: begin
              stat_d[ST_BSY] = 1'b0;
              stat_d[ST_WFT] = 1'b0;
              stat_d[ST_ERR] = 1'b0;
              stat_d[ST_DRQ] = 1'b1;
              xs_d   = 1'b1;
              xlen_d = PKT_LEN;
              xdir_d = 1'b1;
            end
            ACT_SETF: begin
              stat_d[ST_BSY] = 1'b0;
              stat_d[ST_WFT] = 1'b0;
              stat_d[ST_ERR] = 1'b0;
              stat_d[ST_RDY] = 1'b1;
              stat_d[ST_DSC] = 1'b1;
              raise  = 1'b1;
            end
            default: ;
          endcase
        end
        OFF_DEVCTL: begin
          ctrl_d = wr_data;
          if (srst_rise) begin
            stat_d           = 8'h90;
            err_d            = 8'h01;
            cmd_d            = 8'h00;
            ctrl_d[CTL_NIEN] = 1'b0;
          end else if (srst_fall) begin
            stat_d[ST_BSY] = 1'b0;
            stat_d[ST_RDY] = 1'b1;
            dh_d[3:0]      = 4'h0;
          end
        end
        default: ;
      endcase
    end
    irq_d = raise && !ctrl_q[CTL_NIEN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 8'h01;
      stat_q <= 8'h00;
      ctrl_q <= 8'h08;
      feat_q <= 8'h00;
      dh_q   <= 8'h00;
      cmd_q  <= 8'h00;
      irq_q  <= 1'b0;
      xs_q   <= 1'b0;
      xlen_q <= '0;
      xdir_q <= 1'b0;
    end else begin
      if (wr_en) begin
        err_q  <= err_d;
        stat_q <= stat_d;
        ctrl_q <= ctrl_d;
        feat_q <= feat_d;
        dh_q   <= dh_d;
        cmd_q  <= cmd_d;
        xlen_q <= xlen_d;
        xdir_q <= xdir_d;
      end
      irq_q <= irq_d;
      xs_q  <= xs_d;
    end
  end

  assign irq            = irq_q;
  assign xfer_start     = xs_q;
  assign xfer_len       = xlen_q;
  assign xfer_to_device = xdir_q;
  assign active_slot    = sel;
  assign cmd_code       = cmd_q;
  assign features       = feat_q;

  p_dh_forced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_DRVHD) |=> ((dh_q & 8'hA0) == 8'hA0));

  p_srst_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    srst_rise |=> (stat_q == 8'h90 && err_q == 8'h01 && cmd_q == 8'h00 && !ctrl_q[CTL_NIEN]));

  p_xfer_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> ((xfer_len == ID_LEN && !xfer_to_device) ||
                    (xfer_len == PKT_LEN && xfer_to_device)));

  p_unknown_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && act == ACT_NONE) |=> ($stable(stat_q) && $stable(err_q) && !irq && !xfer_start));

  p_irq_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(wr_cmd && !ctrl_q[CTL_NIEN]));
endmodule

// File: tb/ata_taskfile_ctrl_tb_top.sv
`timescale 1ns/1ps
module ata_taskfile_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  addr;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data;
  logic [1:0]  slot_present;
  logic [1:0]  slot_is_packet;
  logic        irq, xfer_start, xfer_to_device, active_slot;
  logic [11:0] xfer_len;
  logic [7:0]  cmd_code, features;

  always #4 clk = ~clk;

  ata_taskfile_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .slot_present(slot_present), .slot_is_packet(slot_is_packet),
    .irq(irq), .xfer_start(xfer_start), .xfer_len(xfer_len),
    .xfer_to_device(xfer_to_device), .active_slot(active_slot),
    .cmd_code(cmd_code), .features(features)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0] m_err, m_stat, m_ctrl, m_dh;
  logic [7:0] m_sc [2];
  logic [7:0] m_sn [2];
  logic [7:0] m_cl [2];
  logic [7:0] m_ch [2];

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int kind(int s);
    if (!slot_present[s]) return 0;
    return slot_is_packet[s] ? 2 : 1;
  endfunction

  function automatic logic [7:0] exp_read(int a);
    int s = m_dh[4];
    if (a == 9) return 8'hFF;
    if (kind(s) == 0) return (a == 6) ? 8'hA0 : 8'h00;
    case (a)
      1: return m_err;
      2: return m_sc[s];
      3: return m_sn[s];
      4: return m_cl[s];
      5: return m_ch[s];
      6: return m_dh;
      7, 8: return m_stat;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    m_err = 8'h01; m_stat = 8'h00; m_ctrl = 8'h08; m_dh = 8'h00;
    for (int s = 0; s < 2; s++) begin
      m_sc[s] = 8'd1; m_sn[s] = 8'd1; m_cl[s] = 8'd0; m_ch[s] = 8'd0;
    end
  endtask

  task automatic model_write(int a, logic [7:0] d, output bit e_irq, output bit e_xs,
                             output logic [11:0] e_len, output bit e_dir);
    int s = m_dh[4];
    bit rz = 1'b0;
    bit ab = 1'b0;
    e_xs = 1'b0; e_len = 12'd0; e_dir = 1'b0;
    case (a)
      2: m_sc[s] = d;
      3: m_sn[s] = d;
      4: m_cl[s] = d;
      5: m_ch[s] = d;
      6: begin
        m_dh = d | 8'hA0;
        if (kind(d[4]) == 0) begin m_err |= 8'h04; m_stat |= 8'h01; end
      end
      7: begin
        case (d)
          8'hEC: if (kind(s) == 1) begin
                   m_err = 0; m_stat = 8'h58; rz = 1; e_xs = 1; e_len = 512; e_dir = 0;
                 end else ab = 1;
          8'hA1: if (kind(s) == 2) begin
                   m_err = 0; m_stat = 8'h58; rz = 1; e_xs = 1; e_len = 512; e_dir = 0;
                 end else ab = 1;
          8'hA0: if (kind(s) == 2) begin
                   m_sc[s] = 1; m_stat &= ~8'hA1; m_stat |= 8'h08; e_xs = 1; e_len = 12; e_dir = 1;
                 end else ab = 1;
          8'hEF: begin m_stat &= ~8'hA1; m_stat |= 8'h50; rz = 1; end
          default: ;
        endcase
        if (ab) begin m_stat = 8'h41; m_err = 8'h04; rz = 1; end
      end
      8: begin
        if (!m_ctrl[2] && d[2]) begin
          m_stat = 8'h90; m_err = 8'h01; m_ctrl = d & ~8'h02;
        end else begin
          if (m_ctrl[2] && !d[2]) begin
            m_stat &= ~8'h80; m_stat |= 8'h40; m_dh &= 8'hF0;
            for (int k = 0; k < 2; k++) begin
              m_sc[k] = 1; m_sn[k] = 1;
              m_cl[k] = (kind(k) == 2) ? 8'h14 : 8'h00;
              m_ch[k] = (kind(k) == 2) ? 8'hEB : 8'h00;
            end
          end
          m_ctrl = d;
        end
      end
      default: ;
    endcase
    e_irq = rz && !m_ctrl[1];
  endtask

  task automatic check_reads(string req);
    for (int a = 0; a < 11; a++) begin
      addr = 4'(a);
      #1;
      chk(req, $sformatf("read offset %0d", a), {8'h00, rd_data}, {8'h00, exp_read(a)});
    end
  endtask

  task automatic do_write(int a, logic [7:0] d, string req);
    bit e_irq, e_xs, e_dir;
    logic [11:0] e_len;
    @(negedge clk);
    wr_en = 1'b1; addr = 4'(a); wr_data = d;
    model_write(a, d, e_irq, e_xs, e_len, e_dir);
    @(negedge clk);
    wr_en = 1'b0;
    chk(req, "irq after write", {15'd0, irq}, {15'd0, e_irq});
    chk(req, "xfer_start", {15'd0, xfer_start}, {15'd0, e_xs});
    if (e_xs) begin
      chk(req, "xfer_len", {4'd0, xfer_len}, {4'd0, e_len});
      chk(req, "xfer_to_device", {15'd0, xfer_to_device}, {15'd0, e_dir});
    end
    @(negedge clk);
    chk("R12", "irq one cycle wide", {15'd0, irq}, 16'd0);
    check_reads(req);
  endtask

  function automatic logic [7:0] rand_data(int a);
    if (a == 7) begin
      case ($urandom_range(0, 4))
        0: return 8'hEC;
        1: return 8'hA1;
        2: return 8'hA0;
        3: return 8'hEF;
        default: return 8'($urandom());
      endcase
    end
    return 8'($urandom());
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    wr_en = 0; addr = 0; wr_data = 0;
    slot_present = 2'b11; slot_is_packet = 2'b10;
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "irq at reset", {15'd0, irq}, 16'd0);
    chk("R1", "xfer_start at reset", {15'd0, xfer_start}, 16'd0);
    check_reads("R1");

    // R2: forced bits, slot select
    do_write(6, 8'h00, "R2");
    do_write(6, 8'h5F, "R2");
    // R4: per-slot fields, features not readable
    do_write(2, 8'h33, "R4"); do_write(4, 8'h77, "R4"); do_write(5, 8'h88, "R4");
    do_write(6, 8'h40, "R4");
    do_write(2, 8'h11, "R4"); do_write(3, 8'h22, "R4");
    do_write(1, 8'h3C, "R4");
    chk("R4", "features port", {8'h00, features}, 16'h003C);
    do_write(6, 8'h10, "R4");
    // R8 / R7: identify and mismatches
    do_write(6, 8'h00, "R8"); do_write(7, 8'hEC, "R8");
    do_write(7, 8'hA1, "R7");
    do_write(6, 8'h10, "R8"); do_write(7, 8'hA1, "R8");
    do_write(7, 8'hEC, "R7");
    // R9: packet command
    do_write(2, 8'h05, "R9"); do_write(7, 8'hA0, "R9");
    do_write(6, 8'h00, "R9"); do_write(7, 8'hA0, "R9");
    // R10, R11
    do_write(7, 8'hEF, "R10");
    do_write(7, 8'h30, "R11");
    do_write(7, 8'h00, "R11");
    // R12: masked interrupt
    do_write(8, 8'h0A, "R12"); do_write(7, 8'hEF, "R12"); do_write(7, 8'hEC, "R12");
    do_write(8, 8'h08, "R12"); do_write(7, 8'hEF, "R12");
    // R5 / R6: soft reset edges
    do_write(6, 8'h1F, "R6"); do_write(4, 8'h99, "R6");
    do_write(8, 8'h0E, "R5");
    do_write(8, 8'h0C, "R5");
    do_write(8, 8'h08, "R6");
    do_write(6, 8'h00, "R6");
    // R3: empty slot selection
    slot_present = 2'b01;
    do_write(6, 8'h10, "R3");
    do_write(2, 8'h44, "R3");
    do_write(6, 8'h00, "R3");

    for (int ph = 0; ph < 3; ph++) begin
      slot_present   = (ph == 0) ? 2'b11 : (ph == 1) ? 2'b10 : 2'b11;
      slot_is_packet = (ph == 0) ? 2'b01 : (ph == 1) ? 2'b10 : 2'b00;
      check_reads("R4");
      for (int i = 0; i < 300; i++) begin
        int a = $urandom_range(0, 10);
        do_write(a, rand_data(a), "R3/R5/R6/R8 random");
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule